// File: doc/BRIEF.md
# Eight-bit waveform timer with one compare channel

This block is an 8-bit counter that counts up, or up then down, under a single control register. The register picks one of four waveform modes (free-running, clear-on-compare, fast PWM and phase-correct PWM), the action taken on the waveform pin when the counter meets the compare value, and which of seven prescaled clock-enable taps advances the counter. A setting of zero in the tap field stops the counter.

Software reaches the control register, the compare register and the counter through a small register port with combinational read-back. In the two PWM modes a compare write lands in a holding register and reaches the comparator only when the counter is at its peak, so a duty-cycle change never produces a glitched period. In the other two modes a compare write takes effect at once. The block reports counter overflow and compare match as one-cycle event pulses. It also drives a waveform output and an enable that tells the pad logic to hand the pin over to the timer.

Top module: `wave_timer8`

## Requirements
- R1: After reset the counter, compare value, control register, waveform output, output enable and both event pulses are all zero.
- R2: Register addresses are 0 for control, 1 for compare and 2 for counter, and address 3 reads zero. The control fields are bit 7 force strobe, bit 6 mode low bit, bits 5:4 output action, bit 3 mode high bit and bits 2:0 tap select. Bit 7 always reads back as zero.
- R3: A tap-select value of 0 stops the counter. A value n from 1 to 7 advances the counter only in cycles where tick_taps[n-1] is high.
- R4: Mode 0 (mode bits 00) counts up and wraps from 0xFF to 0x00. ovf_flag pulses for exactly one cycle after the tick taken at 0xFF.
- R5: Mode 2 (high mode bit only) clears the counter to zero on the tick where the counter equals the compare value, and pulses cmp_flag. A compare write is used from the very next tick.
- R6: Mode 3 (both mode bits) counts up and wraps at 0xFF with ovf_flag at that tick. With output action 2 the output sets at the wrap and clears on a match; action 3 inverts both. If both events fall on the same tick, the wrap action wins.
- R7: Mode 1 (low mode bit only) counts 0..0xFF..0, turning at 0xFF to 0xFE and at 0x00 to 0x01. ovf_flag pulses after the tick taken at 0x00 while counting down. With output action 2 a match clears the output while counting up and sets it while counting down; action 3 inverts both.
- R8: In modes 1 and 3 a compare write changes the read-back value at once. The comparator keeps its old value until the tick taken at 0xFF while counting up.
- R9: In modes 0 and 2 a compare match applies the output action: 1 toggles, 2 clears, 3 sets, and 0 leaves the output alone.
- R10: A control write with bit 7 set, and whose new mode bits select mode 0 or 2, applies the new output action to the waveform at once. It raises no cmp_flag and does not clear the counter. In modes 1 and 3 the force bit has no effect.
- R11: wave_oe is high whenever the output action field is nonzero.
- R12: A counter write loads the value, even if a tick arrives in the same cycle. It also suppresses the compare match on the next tick, so loading the compare value raises no cmp_flag and causes no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_taps | input | 7 | Prescaled clock-enable taps, one per tap-select value 1..7 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 compare, 2 counter) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| wave_out | output | 1 | Compare-driven waveform |
| wave_oe | output | 1 | High when the timer owns the pin |
| ovf_flag | output | 1 | One-cycle overflow event |
| cmp_flag | output | 1 | One-cycle compare-match event |

## Verification
The assertions treat the tap inputs as free-running enables. They assume a register write touches exactly one address per cycle, and that a mode change never coincides with a compare write. The step and clear properties also take for granted that a counter write and a tick in the same cycle resolve in favour of the write. The directed stimulus keeps to this: it writes one register per cycle and raises a single tap for one cycle per step. It changes modes only while the counter is idle, which leaves the expected count, direction and waveform level known before each step.

// File: rtl/wave_timer8_pkg.sv
package wave_timer8_pkg;

  localparam int DW     = 8;
  localparam int CS_W   = 3;
  localparam int N_TAPS = (1 << CS_W) - 1;
  localparam int AW     = 2;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_CMP  = 2'd1;
  localparam logic [AW-1:0] A_CNT  = 2'd2;

  localparam int B_FORCE = 7;
  localparam int B_WGM0  = 6;
  localparam int B_COM1  = 5;
  localparam int B_COM0  = 4;
  localparam int B_WGM1  = 3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PCPWM  = 2'd1,
    MODE_CTC    = 2'd2,
    MODE_FPWM   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    COM_OFF    = 2'd0,
    COM_TOGGLE = 2'd1,
    COM_CLEAR  = 2'd2,
    COM_SET    = 2'd3
  } com_e;

  typedef struct packed {
    logic          down;
    logic [DW-1:0] val;
  } cnt_state_t;

  function automatic mode_e decode_mode(logic [DW-1:0] c);
    return mode_e'({c[B_WGM1], c[B_WGM0]});
  endfunction

  function automatic logic is_pwm(mode_e m);
    return (m == MODE_PCPWM) || (m == MODE_FPWM);
  endfunction

  function automatic logic tap_pick(logic [N_TAPS-1:0] taps, logic [CS_W-1:0] cs);
    if (cs == '0) return 1'b0;
    return taps[cs - 1'b1];
  endfunction

  function automatic logic nonpwm_level(com_e c, logic cur);
    case (c)
      COM_TOGGLE: return ~cur;
      COM_CLEAR:  return 1'b0;
      COM_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

  // One counter step taken on an enabled tick.
  function automatic cnt_state_t step_count(mode_e m, cnt_state_t s, logic match);
    cnt_state_t n;
    n.down = (m == MODE_PCPWM) ? s.down : 1'b0;
    n.val  = s.val + 1'b1;
    if (m == MODE_CTC && match) begin
      n.val = '0;
    end else if (m == MODE_PCPWM) begin
      if (!s.down) begin
        if (s.val == '1) begin
          n.val  = s.val - 1'b1;
          n.down = 1'b1;
        end
      end else if (s.val == '0) begin
        n.down = 1'b0;
      end else begin
        n.val = s.val - 1'b1;
      end
    end
    return n;
  endfunction

  // Waveform level after one cycle of events.
  function automatic logic wave_next(mode_e m, com_e c, logic cur,
                                     logic match, logic down, logic wrap);
    logic n;
    n = cur;
    case (m)
      MODE_NORMAL, MODE_CTC: begin
        if (match) n = nonpwm_level(c, cur);
      end
      MODE_FPWM: begin
        if (wrap) begin
          if (c == COM_CLEAR)    n = 1'b1;
          else if (c == COM_SET) n = 1'b0;
        end else if (match) begin
          if (c == COM_CLEAR)    n = 1'b0;
          else if (c == COM_SET) n = 1'b1;
        end
      end
      default: begin
        if (match) begin
          if (c == COM_CLEAR)    n = down;
          else if (c == COM_SET) n = ~down;
        end
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/wave_timer8_counter.sv
module wave_timer8_counter
  import wave_timer8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  mode_e         mode,
  input  logic [DW-1:0] cmp_act,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt,
  output logic          down,
  output logic          step,
  output logic          ev_match,
  output logic          ev_wrap,
  output logic          ev_ovf,
  output logic          ev_top
);

  logic       blk_q;
  logic       at_max;
  logic       at_zero;
  cnt_state_t cur_s;
  cnt_state_t nxt_s;

  assign at_max   = (cnt == '1);
  assign at_zero  = (cnt == '0);
  assign step     = tick & ~load;
  assign ev_match = step & ~blk_q & (cnt == cmp_act);
  assign ev_wrap  = step & at_max & (mode != MODE_PCPWM);
  assign ev_ovf   = (mode == MODE_PCPWM) ? (step & down & at_zero) : ev_wrap;
  assign ev_top   = step & at_max & ~down & is_pwm(mode);

  assign cur_s.down = down;
  assign cur_s.val  = cnt;

  always_comb begin
    nxt_s.down = (mode == MODE_PCPWM) ? down : 1'b0;
    nxt_s.val  = cnt;
    if (load) begin
      nxt_s.val = load_val;
    end else if (step) begin
      nxt_s = step_count(mode, cur_s, ev_match);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      down  <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      cnt  <= nxt_s.val;
      down <= nxt_s.down;
      if (load)      blk_q <= 1'b1;
      else if (step) blk_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wave_timer8_compare.sv
module wave_timer8_compare
  import wave_timer8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm,
  input  logic          ev_top,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmp_buf,
  output logic [DW-1:0] cmp_act
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr) cmp_buf <= wdata;
      if (!pwm)        cmp_act <= wr ? wdata : cmp_buf;
      else if (ev_top) cmp_act <= cmp_buf;
    end
  end

endmodule

// File: rtl/wave_timer8_wave.sv
module wave_timer8_wave
  import wave_timer8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  com_e  com,
  input  logic  ev_match,
  input  logic  down,
  input  logic  ev_wrap,
  input  logic  force_hit,
  input  com_e  force_com,
  output logic  wave
);

  logic wave_nx;

  always_comb begin
    if (force_hit) wave_nx = nonpwm_level(force_com, wave);
    else           wave_nx = wave_next(mode, com, wave, ev_match, down, ev_wrap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= wave_nx;
  end

endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import wave_timer8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tick_taps,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              wave_out,
  output logic              wave_oe,
  output logic              ovf_flag,
  output logic              cmp_flag
);

  logic [DW-2:0]   ctrl_q;
  mode_e           mode;
  com_e            com;
  logic [CS_W-1:0] cs_sel;
  logic            tick;
  logic            pwm;

  logic            ctrl_wr;
  logic            cmp_wr;
  logic            cnt_wr;
  logic            force_hit;
  com_e            force_com;

  logic [DW-1:0]   cnt_q;
  logic            down;
  logic            step;
  logic            ev_match;
  logic            ev_wrap;
  logic            ev_ovf;
  logic            ev_top;
  logic [DW-1:0]   cmp_buf;
  logic [DW-1:0]   cmp_act;

  assign mode   = decode_mode({1'b0, ctrl_q});
  assign com    = com_e'(ctrl_q[B_COM1:B_COM0]);
  assign cs_sel = ctrl_q[CS_W-1:0];
  assign pwm    = is_pwm(mode);
  assign tick   = tap_pick(tick_taps, cs_sel);

  assign ctrl_wr   = bus_we & (bus_addr == A_CTRL);
  assign cmp_wr    = bus_we & (bus_addr == A_CMP);
  assign cnt_wr    = bus_we & (bus_addr == A_CNT);
  assign force_com = com_e'(bus_wdata[B_COM1:B_COM0]);
  assign force_hit = ctrl_wr & bus_wdata[B_FORCE] & ~is_pwm(decode_mode(bus_wdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[DW-2:0];
      ovf_flag <= ev_ovf;
      cmp_flag <= ev_match;
    end
  end

  wave_timer8_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .cmp_act  (cmp_act),
    .load     (cnt_wr),
    .load_val (bus_wdata),
    .cnt      (cnt_q),
    .down     (down),
    .step     (step),
    .ev_match (ev_match),
    .ev_wrap  (ev_wrap),
    .ev_ovf   (ev_ovf),
    .ev_top   (ev_top)
  );

  wave_timer8_compare u_compare (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm     (pwm),
    .ev_top  (ev_top),
    .wr      (cmp_wr),
    .wdata   (bus_wdata),
    .cmp_buf (cmp_buf),
    .cmp_act (cmp_act)
  );

  wave_timer8_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .com       (com),
    .ev_match  (ev_match),
    .down      (down),
    .ev_wrap   (ev_wrap),
    .force_hit (force_hit),
    .force_com (force_com),
    .wave      (wave_out)
  );

  assign wave_oe = (com != COM_OFF);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {1'b0, ctrl_q};
      A_CMP:   bus_rdata = cmp_buf;
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wave_timer8_chk.sv
module wave_timer8_chk
  import wave_timer8_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            wave_oe,
  input logic            ovf_flag,
  input logic            cmp_flag,
  input logic [DW-1:0]   cnt_q,
  input logic [1:0]      mode,
  input logic [CS_W-1:0] cs_sel,
  input logic            pwm,
  input logic            step,
  input logic            ev_match,
  input logic            ev_top,
  input logic [DW-1:0]   cmp_act,
  input logic            force_hit
);

  AST_OE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && bus_wdata[B_COM1:B_COM0] != 2'b00) |=> wave_oe); // R11

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == '0 && !(bus_we && bus_addr == A_CNT)) |=> $stable(cnt_q)); // R3

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == 2'd0) |=> (cnt_q == DW'($past(cnt_q) + 1'b1))); // R4

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> !ovf_flag); // R4

  AST_CTC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && mode == 2'd2) |=> (cnt_q == '0)); // R5

  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !ev_top) |=> $stable(cmp_act)); // R8

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hit && !ev_match) |=> !cmp_flag); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CNT) |=> (cnt_q == $past(bus_wdata))); // R12

endmodule

bind wave_timer8 wave_timer8_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .wave_oe   (wave_oe),
  .ovf_flag  (ovf_flag),
  .cmp_flag  (cmp_flag),
  .cnt_q     (cnt_q),
  .mode      (mode),
  .cs_sel    (cs_sel),
  .pwm       (pwm),
  .step      (step),
  .ev_match  (ev_match),
  .ev_top    (ev_top),
  .cmp_act   (cmp_act),
  .force_hit (force_hit)
);

// File: tb/test_wave_timer8.sv
module test_wave_timer8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] tick_taps;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wave_out;
  logic       wave_oe;
  logic       ovf_flag;
  logic       cmp_flag;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  localparam logic [1:0] RC = 2'd0, RP = 2'd1, RN = 2'd2;

  always #4 clk = ~clk;

  wave_timer8 i_wave_timer8 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_taps (tick_taps),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wave_out  (wave_out),
    .wave_oe   (wave_oe),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [1:0] a, logic [7:0] d, logic [6:0] taps);
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    tick_taps = taps;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
    tick_taps = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 7'h00);
  endtask

  task automatic step();
    cyc(1'b0, RC, 8'h00, 7'h01);
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_cnt(string tag, logic [7:0] exp);
    logic [7:0] v;
    rd(RN, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(RC, v); chk("R1 ctrl", v, 0);
    rd(RP, v); chk("R1 cmp", v, 0);
    rd(RN, v); chk("R1 cnt", v, 0);
    chk("R1 outs", {wave_out, wave_oe, ovf_flag, cmp_flag}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(RC, 8'hFF);
    rd(RC, v); chk("R2 force reads zero", v, 8'h7F);
    chk("R11 oe on", wave_oe, 1);
    wr(RP, 8'h5A); rd(RP, v); chk("R2 cmp readback", v, 8'h5A);
    wr(RN, 8'h33); rd(RN, v); chk("R2 cnt readback", v, 8'h33);
    rd(2'd3, v); chk("R2 addr3 zero", v, 0);
    wr(RC, 8'h00);
    chk("R11 oe off", wave_oe, 0);
  endtask

  task automatic t_prescale();
    wr(RN, 8'h10);
    for (int i = 0; i < 5; i++) cyc(1'b0, RC, 8'h00, 7'h7F);
    chk_cnt("R3 stopped", 8'h10);
    wr(RC, 8'h03);
    for (int i = 0; i < 2; i++) cyc(1'b0, RC, 8'h00, 7'h03);
    chk_cnt("R3 other taps ignored", 8'h10);
    for (int i = 0; i < 3; i++) cyc(1'b0, RC, 8'h00, 7'h04);
    chk_cnt("R3 selected tap", 8'h13);
  endtask

  task automatic t_normal();
    wr(RC, 8'h01); wr(RP, 8'h10); wr(RN, 8'hFD);
    step(); step();
    chk_cnt("R4 at max", 8'hFF); chk("R4 no ovf early", ovf_flag, 0);
    step();
    chk_cnt("R4 wrap", 8'h00); chk("R4 ovf pulse", ovf_flag, 1);
    step();
    chk("R4 ovf one cycle", ovf_flag, 0); chk_cnt("R4 count on", 8'h01);
  endtask

  task automatic t_ctc();
    wr(RP, 8'h03); wr(RC, 8'h09); wr(RN, 8'h00);
    step(); step(); step();
    chk_cnt("R5 reach cmp", 8'h03); chk("R5 no flag yet", cmp_flag, 0);
    step();
    chk_cnt("R5 cleared", 8'h00); chk("R5 cmp flag", cmp_flag, 1);
    step();
    chk("R5 flag drops", cmp_flag, 0);
    wr(RP, 8'h01);
    step();
    chk_cnt("R5 immediate cmp", 8'h00); chk("R5 flag new cmp", cmp_flag, 1);
  endtask

  task automatic t_force();
    logic [7:0] v;
    wr(RC, 8'h30);
    wr(RC, 8'hB0);
    chk("R10 force set", wave_out, 1); chk("R10 no flag", cmp_flag, 0);
    rd(RC, v); chk("R2 strobe not stored", v, 8'h30);
    wr(RC, 8'hA0);
    chk("R10 force clear", wave_out, 0);
    wr(RC, 8'h08); wr(RP, 8'h07); wr(RN, 8'h07);
    wr(RC, 8'h98);
    chk("R10 force toggle ctc", wave_out, 1);
    chk_cnt("R10 no ctc clear", 8'h07); chk("R10 no flag ctc", cmp_flag, 0);
    wr(RC, 8'hF8);
    chk("R10 ignored in pwm", wave_out, 1);
    wr(RC, 8'hA0);
    chk("R10 force clear again", wave_out, 0);
  endtask

  task automatic t_nonpwm();
    wr(RP, 8'h05); wr(RC, 8'h11);
    chk("R11 oe toggle mode", wave_oe, 1);
    wr(RN, 8'h04); step();
    chk("R9 before match", wave_out, 0);
    step();
    chk("R9 toggle up", wave_out, 1); chk("R9 flag", cmp_flag, 1);
    wr(RN, 8'h04); step(); step();
    chk("R9 toggle down", wave_out, 0);
    wr(RC, 8'h31); wr(RN, 8'h04); step(); step();
    chk("R9 set", wave_out, 1);
    wr(RC, 8'h21); wr(RN, 8'h04); step(); step();
    chk("R9 clear", wave_out, 0);
    wr(RC, 8'h01);
    chk("R11 oe off", wave_oe, 0);
  endtask

  task automatic t_block();
    wr(RC, 8'h09); wr(RP, 8'h20); wr(RN, 8'h20);
    step();
    chk_cnt("R12 match blocked", 8'h21); chk("R12 no flag", cmp_flag, 0);
    cyc(1'b1, RN, 8'h40, 7'h01);
    chk_cnt("R12 write beats tick", 8'h40);
    step();
    chk_cnt("R12 resumes", 8'h41);
  endtask

  task automatic t_fpwm();
    logic [7:0] v;
    wr(RC, 8'h01); wr(RP, 8'h80);
    wr(RC, 8'h69); wr(RP, 8'h02);
    rd(RP, v); chk("R8 buffer readback", v, 8'h02);
    wr(RN, 8'h01); step(); step();
    chk("R8 old cmp in use", cmp_flag, 0); chk("R8 wave kept", wave_out, 0);
    wr(RN, 8'hFE); step(); step();
    chk("R6 set at wrap", wave_out, 1); chk("R6 ovf at max", ovf_flag, 1);
    chk_cnt("R6 wrapped", 8'h00);
    step(); step();
    chk("R6 high before match", wave_out, 1);
    step();
    chk("R6 clear on match", wave_out, 0); chk("R8 new cmp loaded", cmp_flag, 1);
    wr(RC, 8'h79); wr(RN, 8'hFE); step(); step();
    chk("R6 inverted wrap", wave_out, 0);
    step(); step(); step();
    chk("R6 inverted match", wave_out, 1);
  endtask

  task automatic t_pcpwm();
    wr(RC, 8'h01); wr(RP, 8'hFD); wr(RC, 8'h61);
    wr(RN, 8'hFC); step(); step();
    chk("R7 up match clears", wave_out, 0); chk("R7 flag up", cmp_flag, 1);
    step(); step();
    chk_cnt("R7 turn at top", 8'hFE);
    step(); step();
    chk("R7 down match sets", wave_out, 1); chk_cnt("R7 counting down", 8'hFC);
    wr(RN, 8'h02); step(); step();
    chk("R7 no ovf at max path", ovf_flag, 0);
    step();
    chk("R7 ovf at bottom", ovf_flag, 1); chk_cnt("R7 turn at bottom", 8'h01);
    step();
    chk("R7 ovf one cycle", ovf_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; tick_taps = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_prescale();
    t_normal();
    t_ctc();
    t_force();
    t_nonpwm();
    t_block();
    t_fpwm();
    t_pcpwm();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule